// File: doc/BRIEF.md
# External Interrupt Arbiter

This block gathers a parameterised set of level-sensitive external interrupt lines for a single hart. It forwards one request line to that hart. Each line passes through its own gateway, which latches a pending bit. Software programs, through a small register port, a priority for each source, an enable mask and one priority threshold. The arbiter continuously selects the best eligible source. A source is eligible when it is pending and enabled and its priority is strictly greater than the threshold. The request line stays high while such a source exists.

The hart services an interrupt by reading the claim register, which returns the winning source ID and takes that source out of the pending set. The handler finishes by writing the same ID to the same address, which completes it. Until then the gateway of that source ignores its input line. If the line is still asserted after completion, the source becomes pending again. ID 0 means "no interrupt". Register reads are combinational from the address. The claim side effect and all writes take place at the rising clock edge on which `reg_re_i` or `reg_we_i` is sampled high.

Top module: `ext_irq_arbiter`

## Requirements
- R1: After synchronous reset, all priorities, enables, pending bits and the threshold read as 0, `irq_o` is 0, and a claim read returns 0.
- R2: A source whose line `src_i[k-1]` is high at a clock edge has ID k; its pending bit is set by that edge. If the source is enabled and its priority exceeds the threshold, `irq_o` is high after that edge, with no further delay.
- R3: A source whose enable bit is 0 never drives `irq_o` and is never returned by a claim, but its pending bit is still visible. In the pending register (address 2) and the enable register (address 3), bit k belongs to ID k, and bit 0 always reads 0.
- R4: The threshold register is at address 0. A source whose priority is equal to or below the threshold cannot raise `irq_o`. One priority step above the threshold is enough.
- R5: A source with priority 0 never interrupts and is never claimed, whatever the threshold.
- R6: A read of address 1 (claim) returns the eligible source with the highest priority, in bits [ID_W-1:0].
- R7: Among eligible sources of equal priority, the lowest ID is returned.
- R8: A claim clears the pending bit of the returned ID. That source stays non-pending while its line is held high, until it is completed. If its line is low at completion, it stays non-pending.
- R9: Writing the claimed ID to address 1 completes it, and a still-asserted line then re-pends it one edge later. Writing any other ID has no effect.
- R10: A claim read with no eligible source returns 0 and leaves the pending set unchanged.
- R11: The priority of ID k is read and written at address 32+k. Only the low PRIO_W bits are stored; higher write bits read back as 0. A write of all ones to the enable register reads back with bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt lines; bit k-1 is source ID k |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (claim side effect) |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | External interrupt request to the hart |

## Verification
A wrong gateway bit shows up in two places: in the pending register on the next read, and in the ID that the next claim returns. The request line shows any error on the next edge without delay, because it is combinational from registered state. A gateway that fails to record a claim betrays itself at once: a source held high re-pends one edge after its claim, so a read of the pending register directly after the claim exposes it. A wrong priority comparison or tie-break appears in the first claim made with two competing sources. The sequence therefore reads the pending register or claims directly after each change of state.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 5;

    typedef enum logic [2:0] {
        RK_THRESH,
        RK_CLAIM,
        RK_PEND,
        RK_ENABLE,
        RK_PRIO,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } reg_dec_t;

    // Map an address onto a register kind and, for priorities, a source index.
    function automatic reg_dec_t decode_reg(logic [ADDR_W-1:0] addr);
        reg_dec_t d;
        d.idx  = addr[IDX_W-1:0];
        d.kind = RK_NONE;
        if (addr[ADDR_W-1:IDX_W] == 2'b01) begin
            d.kind = RK_PRIO;
        end else begin
            case (addr)
                7'd0:    d.kind = RK_THRESH;
                7'd1:    d.kind = RK_CLAIM;
                7'd2:    d.kind = RK_PEND;
                7'd3:    d.kind = RK_ENABLE;
                default: d.kind = RK_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);

    logic pend_q;
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else if (claim_i) begin
            pend_q <= 1'b0;
            busy_q <= 1'b1;
        end else begin
            if (level_i && !busy_q) begin
                pend_q <= 1'b1;
            end
            if (done_i) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;
    assign busy_o = busy_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC:0]             pend_i,
    input  logic [NUM_SRC:0]             en_i,
    input  logic [NUM_SRC:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              win_id_o,
    output logic                         any_o
);

    logic [NUM_SRC:0]  elig;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        elig[0] = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            elig[i] = pend_i[i] && en_i[i] && (prio_i[i] > thr_i);
        end
    end

    // Ascending scan with strict compare keeps the lowest ID on ties.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (elig[i] && (best_id == '0 || prio_i[i] > best_p)) begin
                best_id = ID_W'(i);
                best_p  = prio_i[i];
            end
        end
    end

    assign win_id_o = best_id;
    assign any_o    = |elig;

endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 reg_we_i,
    input  logic                 reg_re_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 irq_o
);

    localparam int ID_W = $clog2(NUM_SRC + 1);

    reg_dec_t                    dec;
    logic [NUM_SRC:0]            lvl;
    logic [NUM_SRC:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC:0]            en_q;
    logic [PRIO_W-1:0]           thr_q;
    logic [NUM_SRC:0]            pend_vec;
    logic [NUM_SRC:0]            busy_vec;
    logic [NUM_SRC:0]            claim_hit;
    logic [NUM_SRC:0]            done_hit;
    logic [ID_W-1:0]             win_id;
    logic                        any_elig;
    logic                        claim_fire;
    logic                        done_fire;

    assign dec        = decode_reg(reg_addr_i);
    assign lvl        = {src_i, 1'b0};
    assign claim_fire = reg_re_i && (dec.kind == RK_CLAIM) && (win_id != '0);
    assign done_fire  = reg_we_i && (dec.kind == RK_CLAIM);

    assign pend_vec[0]  = 1'b0;
    assign busy_vec[0]  = 1'b0;
    assign claim_hit[0] = 1'b0;
    assign done_hit[0]  = 1'b0;

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
        assign claim_hit[k] = claim_fire && (win_id == ID_W'(k));
        assign done_hit[k]  = done_fire && (reg_wdata_i == DATA_W'(k));

        irq_gateway u_gw (
            .clk     (clk),
            .rst     (rst),
            .level_i (lvl[k]),
            .claim_i (claim_hit[k]),
            .done_i  (done_hit[k]),
            .pend_o  (pend_vec[k]),
            .busy_o  (busy_vec[k])
        );
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (reg_we_i) begin
            case (dec.kind)
                RK_THRESH: thr_q <= reg_wdata_i[PRIO_W-1:0];
                RK_ENABLE: en_q  <= {reg_wdata_i[NUM_SRC:1], 1'b0};
                RK_PRIO: begin
                    for (int i = 1; i <= NUM_SRC; i++) begin
                        if (dec.idx == IDX_W'(i)) begin
                            prio_q[i] <= reg_wdata_i[PRIO_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    irq_pick #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_pick (
        .pend_i   (pend_vec),
        .en_i     (en_q),
        .prio_i   (prio_q),
        .thr_i    (thr_q),
        .win_id_o (win_id),
        .any_o    (any_elig)
    );

    // Read mux.
    always_comb begin
        reg_rdata_o = '0;
        case (dec.kind)
            RK_THRESH: reg_rdata_o[PRIO_W-1:0] = thr_q;
            RK_CLAIM:  reg_rdata_o[ID_W-1:0]   = win_id;
            RK_PEND:   reg_rdata_o[NUM_SRC:0]  = pend_vec;
            RK_ENABLE: reg_rdata_o[NUM_SRC:0]  = en_q;
            RK_PRIO: begin
                for (int i = 1; i <= NUM_SRC; i++) begin
                    if (dec.idx == IDX_W'(i)) begin
                        reg_rdata_o[PRIO_W-1:0] = prio_q[i];
                    end
                end
            end
            default: ;
        endcase
    end

    assign irq_o = any_elig;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         irq_o,
    input logic [ID_W-1:0]              win_id,
    input logic [NUM_SRC:0]             pend,
    input logic [NUM_SRC:0]             busy,
    input logic [NUM_SRC:0]             en,
    input logic [NUM_SRC:0][PRIO_W-1:0] prio,
    input logic [PRIO_W-1:0]            thr,
    input logic                         claim_fire
);

    AST_IRQ_TRACKS_WINNER: assert property (@(posedge clk) disable iff (rst)
        irq_o == (win_id != '0)); // R2

    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (win_id != '0) |-> (pend[win_id] && en[win_id])); // R3

    AST_WINNER_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
        (win_id != '0) |-> (prio[win_id] > thr)); // R4

    AST_WINNER_NONZERO_PRIO: assert property (@(posedge clk) disable iff (rst)
        (win_id != '0) |-> (prio[win_id] != '0)); // R5

    AST_CLAIM_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        claim_fire |=> (!pend[$past(win_id)] && busy[$past(win_id)])); // R8

    AST_NO_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (pend & busy) == '0); // R8

endmodule

bind ext_irq_arbiter irq_arb_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_o      (irq_o),
    .win_id     (win_id),
    .pend       (pend_vec),
    .busy       (busy_vec),
    .en         (en_q),
    .prio       (prio_q),
    .thr        (thr_q),
    .claim_fire (claim_fire)
);

// File: tb/ext_irq_arbiter_tb.sv
`timescale 1ns/100ps
module ext_irq_arbiter_tb;

    localparam int N     = 31;
    localparam int A_THR = 0;
    localparam int A_CLM = 1;
    localparam int A_PND = 2;
    localparam int A_EN  = 3;
    localparam int A_PRI = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    ext_irq_arbiter #(.NUM_SRC(N), .PRIO_W(3)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .reg_we_i    (we),
        .reg_re_i    (re),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: pops expected items pushed by the driver at this low phase.
    initial begin
        exp_t it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 7'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] e, input string tag);
        exp_t it;
        addr = 7'(a); re = 1'b1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        exp_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        irq_chk(1'b0, "R1 irq after reset");
        rd_chk(A_THR, 32'h0, "R1 threshold");
        rd_chk(A_EN,  32'h0, "R1 enable");
        rd_chk(A_PND, 32'h0, "R1 pending");
        rd_chk(A_CLM, 32'h0, "R1 claim");
        rd_chk(A_PRI + 5, 32'h0, "R1 priority");

        // R11 register readback
        wr(A_PRI + 5, 32'hF);
        rd_chk(A_PRI + 5, 32'h7, "R11 priority masked");
        wr(A_PRI + 5, 32'h3);
        rd_chk(A_PRI + 5, 32'h3, "R11 priority");
        wr(A_THR, 32'h2);
        rd_chk(A_THR, 32'h2, "R11 threshold");
        wr(A_EN, 32'hFFFF_FFFF);
        rd_chk(A_EN, 32'hFFFF_FFFE, "R11 enable bit0");
        wr(A_EN, 32'h0);

        // R3 disabled source pends but never interrupts
        src[4] = 1'b1;
        tick();
        rd_chk(A_PND, 32'h0000_0020, "R3 pending visible");
        irq_chk(1'b0, "R3 disabled irq");
        rd_chk(A_CLM, 32'h0, "R3 disabled claim");
        wr(A_EN, 32'h0000_0020);
        irq_chk(1'b1, "R2 enabled irq");

        // R4 strict threshold
        wr(A_THR, 32'h3);
        irq_chk(1'b0, "R4 equal threshold");
        wr(A_THR, 32'h2);
        irq_chk(1'b1, "R4 one above");

        // R5 priority zero source 9, R6 priorities
        wr(A_THR, 32'h0);
        src[8] = 1'b1;
        wr(A_PRI + 12, 32'h6);
        wr(A_EN, 32'h0000_1220);
        src[11] = 1'b1;
        tick();
        rd_chk(A_PND, 32'h0000_1220, "R2 three pending");
        rd_chk(A_CLM, 32'd12, "R6 highest first");
        rd_chk(A_PND, 32'h0000_0220, "R8 claim clears");
        rd_chk(A_CLM, 32'd5, "R6 next");
        rd_chk(A_PND, 32'h0000_0200, "R8 held line stays clear");
        irq_chk(1'b0, "R5 prio zero no irq");
        rd_chk(A_CLM, 32'h0, "R10 empty claim");
        rd_chk(A_PND, 32'h0000_0200, "R10 pending unchanged");

        // R9 completion
        wr(A_CLM, 32'd7);
        tick();
        rd_chk(A_PND, 32'h0000_0200, "R9 wrong id ignored");
        irq_chk(1'b0, "R9 wrong id irq");
        wr(A_CLM, 32'd12);
        tick();
        rd_chk(A_PND, 32'h0000_1200, "R9 re-pend after complete");
        irq_chk(1'b1, "R9 irq after complete");
        wr(A_CLM, 32'd5);
        tick();
        rd_chk(A_PND, 32'h0000_1220, "R9 second complete");

        // R7 ties
        wr(A_PRI + 15, 32'h7);
        wr(A_PRI + 20, 32'h7);
        wr(A_EN, 32'h0010_9220);
        src[14] = 1'b1;
        src[19] = 1'b1;
        tick();
        rd_chk(A_CLM, 32'd15, "R7 tie lowest id");
        rd_chk(A_CLM, 32'd20, "R7 tie second");
        rd_chk(A_CLM, 32'd12, "R6 after ties");
        rd_chk(A_CLM, 32'd5, "R6 last");
        rd_chk(A_CLM, 32'd0, "R10 drained");

        // R8 completion with line low leaves source idle
        src = '0;
        wr(A_CLM, 32'd15);
        wr(A_CLM, 32'd20);
        wr(A_CLM, 32'd12);
        wr(A_CLM, 32'd5);
        tick();
        rd_chk(A_PND, 32'h0000_0200, "R8 low line no re-pend");
        irq_chk(1'b0, "R8 irq idle");

        tick();
        tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule